// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status Unit

This block watches a bank of general-purpose input pins and turns selected pin activity into interrupt requests. Each pin carries two configuration bits, a trigger-select bit and an invert bit. Together they choose one of four conditions: a rising edge, a falling edge, a low level or a high level. A detected condition sets that pin's bit in a bitmapped status register. Software clears status bits by writing ones.

A second bitmapped register, the enable register, decides which status bits may reach the single aggregated interrupt output. That output is registered. The pin levels arrive already synchronized to `clk`, and the per-pin trigger bits come from elsewhere in the chip. Software reaches the status and enable words through a 32-bit register port. That port has a one-cycle write strobe and a combinational read path.

Top module: `gpio_irq_detect`

## Requirements
- R1: With trigger-select 0 and invert 0, a pin whose level goes from 0 in one cycle to 1 in the next sets its status bit at that clock edge.
- R2: With trigger-select 0 and invert 1, a pin whose level goes from 1 to 0 sets its status bit. A rising edge in this mode sets nothing.
- R3: With trigger-select 1 and invert 0, a pin held at 0 sets its status bit on every cycle. A clear written while the level stays low leaves the bit set.
- R4: With trigger-select 1 and invert 1, a pin held at 1 sets its status bit on every cycle.
- R5: The status word for pins 32k..32k+31 sits at byte address 0x80+4k, with pin 32k+j in bit j. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. A status bit is only ever set by a detected event.
- R6: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: The enable word for pins 32k..32k+31 sits at byte address 0x90+4k, with the same bit layout. A write replaces the whole word, a read returns it, and it changes only on a write.
- R8: `irq` equals the OR over all pins of (status AND enable) as it stood one cycle earlier, so it follows a status or enable change by one clock.
- R9: Clearing an enable bit removes the pin from `irq` but leaves its status bit as it was.
- R10: Reset clears all status bits, all enable bits and `irq`. In the first cycle after reset no edge is detected, whatever level the pins hold.
- R11: Reads of any address other than an aligned, implemented status or enable word return 0, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| trig_lvl | input | NUM_PINS | Per-pin trigger select: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Per-pin invert: selects falling edge or high level |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Registered aggregated interrupt |

## Verification
The assertions assume that `pin_lvl`, `trig_lvl` and `trig_inv` are already synchronous to `clk` and settle between edges. They also assume that every register write is a single-cycle strobe whose address and data are valid in that cycle. The stimulus changes inputs only on the falling edge. It holds the trigger configuration steady for stretches of 64 cycles so that edge and level behaviour both get exercised. The write addresses are mostly aligned implemented words, with some unmapped and misaligned ones mixed in on purpose.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] trig_lvl,
  input  logic [NUM_PINS-1:0] trig_inv,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         rd_data,
  output logic                irq
);
  localparam int NW = (NUM_PINS + 31) / 32;
  localparam int PW = NW * 32;
  localparam logic [PW-1:0] PMASK = {PW{1'b1}} >> (PW - NUM_PINS);

  logic [PW-1:0] pin_x, sel_x, inv_x;
  logic [PW-1:0] sts_q, en_q, prev_q;
  logic [PW-1:0] ev, clr, en_wm, wv;
  logic          primed_q;
  logic [1:0]    widx;
  logic          aok, sts_hit, en_hit;

  assign pin_x = PW'(pin_lvl);
  assign sel_x = PW'(trig_lvl);
  assign inv_x = PW'(trig_inv);

  assign widx    = reg_addr[3:2];
  assign aok     = (reg_addr[1:0] == 2'b00) && (int'(widx) < NW);
  assign sts_hit = aok && (reg_addr[7:4] == 4'h8);
  assign en_hit  = aok && (reg_addr[7:4] == 4'h9);
  assign wv      = {NW{reg_wdata}};

  // level: pin equals invert; edge: pin now differs from invert, previously matched
  assign ev = (sel_x & ~(pin_x ^ inv_x))
            | ({PW{primed_q}} & ~sel_x & (pin_x ^ inv_x) & ~(prev_q ^ inv_x));

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign clr[w*32 +: 32]   = (reg_wr && sts_hit && widx == 2'(w)) ? reg_wdata : 32'h0;
    assign en_wm[w*32 +: 32] = (reg_wr && en_hit && widx == 2'(w)) ? PMASK[w*32 +: 32] : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q    <= '0;
      en_q     <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
      irq      <= 1'b0;
    end else begin
      sts_q    <= (sts_q & ~clr) | ev;
      en_q     <= (en_q & ~en_wm) | (wv & en_wm);
      prev_q   <= pin_x;
      primed_q <= 1'b1;
      irq      <= |(sts_q & en_q);
    end
  end

  always_comb begin
    rd_data = 32'h0;
    for (int w = 0; w < NW; w++) begin
      if (widx == 2'(w)) begin
        if (sts_hit) rd_data = sts_q[w*32 +: 32];
        if (en_hit)  rd_data = en_q[w*32 +: 32];
      end
    end
  end

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((sts_q & $past(ev)) == $past(ev)));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((sts_q & $past(clr & ~ev)) == '0));

  assert_set_by_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(ev)) == '0));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(sts_q & en_q))));

  assert_en_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wm != '0) |=> ((en_q & $past(en_wm)) == ($past(wv) & $past(en_wm))));

  assert_en_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wm == '0) |=> $stable(en_q));
endmodule

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_lvl, trig_lvl, trig_inv;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   rd_data;
  logic          irq;

  always #4 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(NP)) u_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_lvl(trig_lvl),
    .trig_inv(trig_inv), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .irq(irq)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [NP-1:0] m_sts, m_en, m_prev;
  logic          m_primed, m_irq;

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    int k;
    k = int'(a[3:2]);
    if (a[1:0] != 2'b00 || k >= NP / 32) return 32'h0;
    if (a[7:4] == 4'h8) return m_sts[k*32 +: 32];
    if (a[7:4] == 4'h9) return m_en[k*32 +: 32];
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [NP-1:0] ev, clr, wm;
    int k;
    @(posedge clk);
    if (!rst_n) begin
      m_sts = '0; m_en = '0; m_prev = '0; m_primed = 1'b0; m_irq = 1'b0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (trig_lvl[i]) ev[i] = (pin_lvl[i] == trig_inv[i]);
        else if (!trig_inv[i]) ev[i] = m_primed && !m_prev[i] && pin_lvl[i];
        else ev[i] = m_primed && m_prev[i] && !pin_lvl[i];
      end
      clr = '0; wm = '0;
      k = int'(reg_addr[3:2]);
      if (reg_wr && reg_addr[1:0] == 2'b00 && k < NP / 32) begin
        if (reg_addr[7:4] == 4'h8) clr[k*32 +: 32] = reg_wdata;
        if (reg_addr[7:4] == 4'h9) wm[k*32 +: 32] = 32'hffff_ffff;
      end
      m_irq    = |(m_sts & m_en);
      m_sts    = (m_sts & ~clr) | ev;
      m_en     = (m_en & ~wm) | ({(NP/32){reg_wdata}} & wm);
      m_prev   = pin_lvl;
      m_primed = 1'b1;
    end
    @(negedge clk);
    chk("R8 irq", {31'h0, irq}, {31'h0, m_irq});
    chk("R5 R7 readback", rd_data, exp_rd(reg_addr));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h80; reg_wdata = '0;
    pin_lvl = '0; trig_lvl = '0; trig_inv = '0;
    pin_lvl[0] = 1'b1;
    m_sts = '0; m_en = '0; m_prev = '0; m_primed = 1'b0; m_irq = 1'b0;
    repeat (3) tick();
    rd_chk("R10 status after reset", 8'h80, 32'h0);
    rd_chk("R10 enable after reset", 8'h90, 32'h0);
    chk("R10 irq after reset", {31'h0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    reg_addr = 8'h80;
    tick();
    rd_chk("R10 no edge in first cycle", 8'h80, 32'h0);

    pin_lvl[1] = 1'b1; tick();
    rd_chk("R1 rising edge", 8'h80, 32'h2);

    trig_inv[2] = 1'b1;
    pin_lvl[2] = 1'b1; tick();
    rd_chk("R2 rising ignored in falling mode", 8'h80, 32'h2);
    pin_lvl[2] = 1'b0; tick();
    rd_chk("R2 falling edge", 8'h80, 32'h6);

    wr(8'h80, 32'h2);
    rd_chk("R5 write one clears", 8'h80, 32'h4);
    wr(8'h80, 32'h0);
    rd_chk("R5 write zero no effect", 8'h80, 32'h4);

    pin_lvl[3] = 1'b0; trig_lvl[3] = 1'b1; tick();
    rd_chk("R3 low level", 8'h80, 32'hc);
    wr(8'h80, 32'h8);
    rd_chk("R3 level re-sets after clear", 8'h80, 32'hc);
    pin_lvl[3] = 1'b1; tick();
    wr(8'h80, 32'h8);
    rd_chk("R3 cleared once inactive", 8'h80, 32'h4);

    trig_lvl[4] = 1'b1; trig_inv[4] = 1'b1; pin_lvl[4] = 1'b1; tick();
    rd_chk("R4 high level", 8'h80, 32'h14);

    pin_lvl[5] = 1'b1;
    wr(8'h80, 32'h20);
    rd_chk("R6 event wins over clear", 8'h80, 32'h34);

    wr(8'h90, 32'h10);
    chk("R8 irq one cycle late", {31'h0, irq}, 32'h0);
    rd_chk("R7 enable readback", 8'h90, 32'h10);
    tick();
    chk("R8 irq asserted", {31'h0, irq}, 32'h1);

    wr(8'h90, 32'h0);
    tick();
    chk("R9 irq drops", {31'h0, irq}, 32'h0);
    rd_chk("R9 status kept", 8'h80, 32'h34);

    pin_lvl[40] = 1'b1; tick();
    rd_chk("R1 word1 rising edge", 8'h84, 32'h100);
    wr(8'h94, 32'h100);
    tick();
    chk("R8 irq from word1", {31'h0, irq}, 32'h1);

    wr(8'h88, 32'hffff_ffff);
    rd_chk("R11 unmapped reads zero", 8'h88, 32'h0);
    rd_chk("R11 misaligned reads zero", 8'h81, 32'h0);
    wr(8'h85, 32'hffff_ffff);
    rd_chk("R11 status untouched", 8'h84, 32'h100);
    rd_chk("R11 enable untouched", 8'h94, 32'h100);

    for (int c = 0; c < 4000; c++) begin
      logic [7:0] alist [8];
      alist = '{8'h80, 8'h84, 8'h90, 8'h94, 8'h88, 8'h98, 8'h81, 8'h00};
      if (c % 64 == 0) begin
        trig_lvl = {$urandom, $urandom};
        trig_inv = {$urandom, $urandom};
      end
      pin_lvl = pin_lvl ^ ({$urandom, $urandom} & {$urandom, $urandom});
      reg_addr = alist[$urandom % 8];
      reg_wr = ($urandom % 4) == 0;
      reg_wdata = $urandom;
      tick();
      reg_wr = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule